// File: doc/BRIEF.md
# Memory-Mapped Character I/O Port

This block sits on a synchronous processor bus as a small slave that joins a keyboard encoder and a character display to software. It claims one aligned group of four word locations: one returns the most recent key code, one accepts a character for the display, one holds two status flags, and the fourth is a spare. Any bus cycle in which the master raises its ready strobe with an address inside that group is answered in the same cycle with an accept strobe. Read data is driven only during such a selected read; in every other cycle it is zero.

On the keyboard side, a rising edge of the encoder's valid line captures the character and raises the key-waiting flag. A processor read of the key location clears that flag. On the display side, a four-state machine tracks whether the display can take a character. A processor write to the character location loads the character and drops the display-ready flag. The machine then presents the character with a valid strobe and holds it until the display lowers its idle line.

The display machine has four states.
- `OUT_BUSY` is the reset state: the display is busy or has not yet reported idle.
- `OUT_READY`: the display-ready flag is set.
- `OUT_PENDING`: a character was written while the display was still busy.
- `OUT_SHOW`: the valid strobe is driven.

Its transitions are:
- BUSY→READY when idle is high and no write occurs.
- BUSY→PENDING on a write.
- READY→SHOW on a write.
- PENDING→SHOW when idle is high.
- SHOW→BUSY when idle is low.

Top module: `char_io_port`

## Requirements
- R1: `bus_srdy` is high in exactly those cycles where `bus_mrdy` is high and `bus_addr[31:2]` equals `BASE_ADDR[31:2]`. Each such cycle is one access, and the register it reaches is chosen by `bus_addr[1:0]`.
- R2: `bus_rdata` is zero in every cycle that is not a selected read (`bus_rnw`=1). A selected read of location 1 or 3 returns zero.
- R3: A rise of `kbd_valid` (high now, low at the previous clock edge) stores `kbd_char` as the key code and sets the key-waiting flag. Both are visible from the next cycle.
- R4: A selected read of location 0 returns the stored key code in bits 7:0 with upper bits zero, and clears the key-waiting flag at that clock edge. If a key rise occurs at the same edge, the flag stays set.
- R5: A key rise while the key-waiting flag is already set overwrites the stored key code.
- R6: A selected read of location 2 returns the key-waiting flag in bit 0 and the display-ready flag in bit 1, with all other bits zero. It changes no state.
- R7: In `OUT_BUSY`, a clock edge with `disp_idle` high and no character write moves to `OUT_READY`, which sets the display-ready flag.
- R8: A selected write to location 1 in `OUT_READY` loads `bus_wdata[7:0]` into `disp_char`, clears the display-ready flag and raises `disp_valid` from the next cycle. `disp_valid` stays high until an edge with `disp_idle` low, after which it is low.
- R9: A character write in `OUT_BUSY` keeps `disp_valid` low and the display-ready flag clear. `disp_valid` rises after the first later edge with `disp_idle` high.
- R10: Writes to locations 0, 2 and 3 are accepted but change no state. Unselected accesses get no accept and change no state.
- R11: After reset, both flags are clear, the key code is zero, `disp_valid` is low and the machine is in `OUT_BUSY`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address from the master |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_mrdy | input | 1 | Master ready: address and command valid |
| bus_wdata | input | DATA_W | Write data |
| bus_srdy | output | 1 | Accept (slave ready) |
| bus_rdata | output | DATA_W | Read data, zero unless selected read |
| kbd_char | input | CHAR_W | Character code from the keyboard encoder |
| kbd_valid | input | 1 | Keyboard valid, rising edge marks a new key |
| disp_idle | input | 1 | Display can take a character |
| disp_char | output | CHAR_W | Character presented to the display |
| disp_valid | output | 1 | Character valid to the display |

## Verification
A wrong display state shows on `disp_valid` one cycle after the faulty edge. It also shows in status bit 1 on the next status read, because the ready flag and the valid strobe are both decoded from the state register. A stuck or mis-cleared key flag appears in status bit 0 on the next read. A lost or wrong key capture appears in the key code returned by the next read of location 0. Decode faults are visible in the same cycle on `bus_srdy` and `bus_rdata`, so the bench compares them on every cycle against its own model.

// File: rtl/char_io_pkg.sv
package char_io_pkg;

    // Display-side handshake states
    typedef enum logic [1:0] {
        OUT_BUSY    = 2'd0,
        OUT_READY   = 2'd1,
        OUT_PENDING = 2'd2,
        OUT_SHOW    = 2'd3
    } out_state_t;

    // Register locations selected by the two low address bits
    typedef enum logic [1:0] {
        LOC_KEY   = 2'd0,
        LOC_CHAR  = 2'd1,
        LOC_STAT  = 2'd2,
        LOC_SPARE = 2'd3
    } loc_t;

endpackage

// File: rtl/cio_bus_decode.sv
module cio_bus_decode
    import char_io_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rnw,
    input  logic              bus_mrdy,
    input  logic [CHAR_W-1:0] key_code,
    input  logic              key_flag,
    input  logic              disp_ready,
    output logic              bus_srdy,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rd_key,
    output logic              wr_char
);

    localparam int SLOT_BITS = 2;

    logic hit;
    logic access;
    loc_t slot;

    assign hit    = (bus_addr[ADDR_W-1:SLOT_BITS] == BASE_ADDR[ADDR_W-1:SLOT_BITS]);
    assign access = hit && bus_mrdy;
    assign slot   = loc_t'(bus_addr[SLOT_BITS-1:0]);

    assign bus_srdy = access;
    assign rd_key   = access && bus_rnw && (slot == LOC_KEY);
    assign wr_char  = access && !bus_rnw && (slot == LOC_CHAR);

    always_comb begin
        bus_rdata = '0;
        if (access && bus_rnw) begin
            unique case (slot)
                LOC_KEY:   bus_rdata[CHAR_W-1:0] = key_code;
                LOC_STAT:  bus_rdata[1:0]        = {disp_ready, key_flag};
                LOC_CHAR:  bus_rdata             = '0;
                LOC_SPARE: bus_rdata             = '0;
            endcase
        end
    end

endmodule

// File: rtl/cio_key_in.sv
module cio_key_in #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_valid,
    input  logic [CHAR_W-1:0] kbd_char,
    input  logic              rd_key,
    output logic [CHAR_W-1:0] key_code,
    output logic              key_flag
);

    logic valid_q;
    logic key_rise;

    assign key_rise = kbd_valid && !valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            key_code <= '0;
            key_flag <= 1'b0;
        end else begin
            valid_q <= kbd_valid;
            if (key_rise) begin
                key_code <= kbd_char;
                key_flag <= 1'b1;
            end else if (rd_key) begin
                key_flag <= 1'b0;
            end
        end
    end

    // R3
    key_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_valid && !$past(kbd_valid)) |=> (key_flag && key_code == $past(kbd_char)));

    // R4
    key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_key && !kbd_valid) |=> !key_flag);

endmodule

// File: rtl/cio_char_out.sv
module cio_char_out
    import char_io_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_char,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              disp_idle,
    output logic [CHAR_W-1:0] disp_char,
    output logic              disp_valid,
    output logic              disp_ready
);

    out_state_t state, state_nx;
    logic [CHAR_W-1:0] char_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= OUT_BUSY;
            char_q <= '0;
        end else begin
            state <= state_nx;
            if (wr_char) begin
                char_q <= wr_data;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OUT_BUSY: begin
                if (wr_char)        state_nx = OUT_PENDING;
                else if (disp_idle) state_nx = OUT_READY;
            end
            OUT_READY: begin
                if (wr_char)        state_nx = OUT_SHOW;
            end
            OUT_PENDING: begin
                if (disp_idle)      state_nx = OUT_SHOW;
            end
            OUT_SHOW: begin
                if (!disp_idle)     state_nx = OUT_BUSY;
            end
        endcase
    end

    always_comb begin
        disp_valid = (state == OUT_SHOW);
        disp_ready = (state == OUT_READY);
        disp_char  = char_q;
    end

    // R7
    ready_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OUT_BUSY && disp_idle && !wr_char) |=> disp_ready);

    // R8
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_idle) |=> !disp_valid);

    // R8
    valid_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> !disp_ready);

    // R10
    char_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_char |=> $stable(disp_char));

endmodule

// File: rtl/char_io_port.sv
module char_io_port
    import char_io_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rnw,
    input  logic              bus_mrdy,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_srdy,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CHAR_W-1:0] kbd_char,
    input  logic              kbd_valid,
    input  logic              disp_idle,
    output logic [CHAR_W-1:0] disp_char,
    output logic              disp_valid
);

    logic [CHAR_W-1:0] key_code;
    logic              key_flag;
    logic              disp_ready;
    logic              rd_key;
    logic              wr_char;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CHAR_W];

    cio_bus_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CHAR_W    (CHAR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .bus_addr   (bus_addr),
        .bus_rnw    (bus_rnw),
        .bus_mrdy   (bus_mrdy),
        .key_code   (key_code),
        .key_flag   (key_flag),
        .disp_ready (disp_ready),
        .bus_srdy   (bus_srdy),
        .bus_rdata  (bus_rdata),
        .rd_key     (rd_key),
        .wr_char    (wr_char)
    );

    cio_key_in #(
        .CHAR_W (CHAR_W)
    ) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .kbd_valid (kbd_valid),
        .kbd_char  (kbd_char),
        .rd_key    (rd_key),
        .key_code  (key_code),
        .key_flag  (key_flag)
    );

    cio_char_out #(
        .CHAR_W (CHAR_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_char    (wr_char),
        .wr_data    (bus_wdata[CHAR_W-1:0]),
        .disp_idle  (disp_idle),
        .disp_char  (disp_char),
        .disp_valid (disp_valid),
        .disp_ready (disp_ready)
    );

    // R1
    accept_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_srdy |-> bus_mrdy);

    // R4
    key_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_key && !kbd_valid) |=> (bus_rdata == '0 || !bus_srdy || bus_addr[1:0] != 2'd2
                                    || bus_rdata[0] == 1'b0));

endmodule

// File: tb/char_io_port_test.sv
module char_io_port_test;

    localparam logic [31:0] BASE  = 32'h0000_4000;
    localparam logic [31:0] NOSEL = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rnw = 1'b0;
    logic        bus_mrdy = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_srdy;
    logic [31:0] bus_rdata;
    logic [7:0]  kbd_char = '0;
    logic        kbd_valid = 1'b0;
    logic        disp_idle = 1'b0;
    logic [7:0]  disp_char;
    logic        disp_valid;

    always #5 clk = ~clk;

    char_io_port #(.BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_mrdy(bus_mrdy),
        .bus_wdata(bus_wdata), .bus_srdy(bus_srdy), .bus_rdata(bus_rdata),
        .kbd_char(kbd_char), .kbd_valid(kbd_valid),
        .disp_idle(disp_idle), .disp_char(disp_char), .disp_valid(disp_valid)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model (0 busy, 1 ready, 2 pending, 3 show)
    bit       m_flag = 0;
    bit [7:0] m_code = 0;
    bit       m_kvp  = 0;
    int       m_st   = 0;
    bit [7:0] m_char = 0;
    logic [31:0] last_rdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [1:0] off);
        logic [31:0] v = '0;
        if (off == 2'd0) v[7:0] = m_code;
        else if (off == 2'd2) v[1:0] = {(m_st == 1), m_flag};
        return v;
    endfunction

    function automatic int next_state(input int st, input bit wr, input bit idle);
        case (st)
            0: return wr ? 2 : (idle ? 1 : 0);
            1: return wr ? 3 : 1;
            2: return idle ? 3 : 2;
            default: return idle ? 3 : 0;
        endcase
    endfunction

    // One bus cycle; called and returning at a falling edge
    task automatic cycle_op(input logic [31:0] a, input bit rnw, input bit mrdy,
                            input logic [31:0] wd, input bit kv, input logic [7:0] kc);
        bit acc, rise, rdk, wrc;
        logic [31:0] er;
        bus_addr = a; bus_rnw = rnw; bus_mrdy = mrdy; bus_wdata = wd;
        kbd_valid = kv; kbd_char = kc;
        #1;
        acc = mrdy && (a[31:2] == BASE[31:2]);
        er  = (acc && rnw) ? exp_read(a[1:0]) : '0;
        chk("R1 accept", {31'd0, bus_srdy}, {31'd0, acc});
        chk((acc && rnw && a[1:0] == 2'd0) ? "R4 key data" :
            (acc && rnw && a[1:0] == 2'd2) ? "R6 status" : "R2 read data", bus_rdata, er);
        last_rdata = bus_rdata;
        rise = kv && !m_kvp;
        m_kvp = kv;
        rdk = acc && rnw && a[1:0] == 2'd0;
        wrc = acc && !rnw && a[1:0] == 2'd1;
        if (rise) begin m_code = kc; m_flag = 1; end
        else if (rdk) m_flag = 0;
        if (wrc) m_char = wd[7:0];
        m_st = next_state(m_st, wrc, disp_idle);
        @(posedge clk);
        @(negedge clk);
        bus_mrdy = 1'b0;
        chk("R8 valid", {31'd0, disp_valid}, {31'd0, (m_st == 3)});
        if (m_st == 3) chk("R8 char", {24'd0, disp_char}, {24'd0, m_char});
    endtask

    task automatic idle_cycle();
        cycle_op(NOSEL, 1'b0, 1'b0, '0, 1'b0, 8'h00);
    endtask
    task automatic rd(input logic [1:0] off);
        cycle_op(BASE + {30'd0, off}, 1'b1, 1'b1, '0, 1'b0, 8'h00);
    endtask
    task automatic wr(input logic [1:0] off, input logic [31:0] d);
        cycle_op(BASE + {30'd0, off}, 1'b0, 1'b1, d, 1'b0, 8'h00);
    endtask
    task automatic press(input logic [7:0] c);
        cycle_op(NOSEL, 1'b0, 1'b0, '0, 1'b1, c);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        int op;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        chk("R11 valid", {31'd0, disp_valid}, 32'd0);
        rd(2'd2); chk("R11 status", last_rdata, 32'd0);
        rd(2'd0); chk("R11 key code", last_rdata, 32'd0);

        // R7: idle sets display-ready
        disp_idle = 1'b1;
        idle_cycle();
        rd(2'd2); chk("R7 ready flag", last_rdata, 32'd2);

        // R3 / R6
        press(8'h41);
        rd(2'd2); chk("R3 key flag", last_rdata, 32'd3);
        rd(2'd2); chk("R6 no side effect", last_rdata, 32'd3);

        // R4: read clears flag
        rd(2'd0); chk("R4 key value", last_rdata, 32'h41);
        rd(2'd2); chk("R4 flag cleared", last_rdata, 32'd2);

        // R5: overwrite
        press(8'h11);
        idle_cycle();
        press(8'h22);
        rd(2'd0); chk("R5 overwrite", last_rdata, 32'h22);

        // R4: set beats clear at the same edge
        cycle_op(BASE, 1'b1, 1'b1, '0, 1'b1, 8'h33);
        chk("R4 old code on collision", last_rdata, 32'h22);
        idle_cycle();
        rd(2'd2); chk("R4 set wins", last_rdata, 32'd3);
        rd(2'd0); chk("R4 new code", last_rdata, 32'h33);

        // R10: ignored writes and unselected access
        wr(2'd0, 32'h77);
        wr(2'd2, 32'h0);
        wr(2'd3, 32'hFF);
        cycle_op(NOSEL + 32'd1, 1'b0, 1'b1, 32'h99, 1'b0, 8'h00);
        rd(2'd0); chk("R10 key code kept", last_rdata, 32'h33);
        rd(2'd2); chk("R10 status kept", last_rdata, 32'd2);
        chk("R10 no display start", {31'd0, disp_valid}, 32'd0);

        // R8: write while ready
        wr(2'd1, 32'h5A);
        chk("R8 valid up", {31'd0, disp_valid}, 32'd1);
        chk("R8 char out", {24'd0, disp_char}, 32'h5A);
        rd(2'd2); chk("R8 ready cleared", last_rdata, 32'd0);
        idle_cycle();
        chk("R8 valid held", {31'd0, disp_valid}, 32'd1);
        disp_idle = 1'b0;
        idle_cycle();
        chk("R8 valid dropped", {31'd0, disp_valid}, 32'd0);

        // R9: write while busy
        wr(2'd1, 32'h66);
        chk("R9 valid held low", {31'd0, disp_valid}, 32'd0);
        rd(2'd2); chk("R9 ready still clear", last_rdata, 32'd0);
        disp_idle = 1'b1;
        idle_cycle();
        chk("R9 valid after idle", {31'd0, disp_valid}, 32'd1);
        chk("R9 char", {24'd0, disp_char}, 32'h66);
        disp_idle = 1'b0;
        idle_cycle();

        // Random mix checked against the model
        for (int i = 0; i < 3000; i++) begin
            op = $urandom % 7;
            case (op)
                0: press(8'($urandom));
                1: rd(2'd0);
                2: rd(2'd2);
                3: wr(2'($urandom), $urandom);
                4: begin
                    a = $urandom;
                    if (a[31:2] == BASE[31:2]) a[31] = ~a[31];
                    cycle_op(a, 1'($urandom), 1'b1, $urandom, 1'b0, 8'h00);
                end
                5: begin disp_idle = ~disp_idle; idle_cycle(); end
                default: rd(2'($urandom));
            endcase
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule